// File: doc/BRIEF.md
# Scanline Sprite Mask Sequencer

This block walks the sprites that land on one scanline, one sprite per valid strobe, and applies the line-masking rule. A sprite placed at horizontal position zero can blank itself and every sprite after it on the same line. That happens only if one of two things is already true: an earlier sprite on the line sat at a nonzero position, or the previous line ran out of pixel capacity. The block holds three flags for this:

- a can-mask flag;
- a sticky masked flag;
- a one-shot overflow flag.

A pending-draw counter is loaded at line start. Each suppressed sprite removes its cell width from that counter, and the counter stops at zero.

For every sprite the block reports one registered decision, either drawn or suppressed, in the cycle after the strobe. A pattern-fetch stage uses this decision, and it takes the counter value as the number of cell draws still owed. A line-start pulse does three things: it clears can-mask and masked, it loads the overflow flag from the previous line's overflow indication, and it reloads the counter.

Top module: `spr_line_mask`

## Requirements
- R1: A sprite evaluated with a nonzero horizontal position sets the can-mask flag (output `can_mask_o`=1 in the next cycle).
- R2: A sprite at horizontal position zero, evaluated while can-mask or overflow is set, sets the masked flag and is itself reported suppressed (`dec_drawn`=0).
- R3: A sprite evaluated while masked is clear, and that does not set masked, is reported drawn (`dec_drawn`=1). This includes a position-zero sprite seen while both can-mask and overflow are clear.
- R4: The overflow flag (`dot_ovf_o`) is cleared by the evaluation of any sprite, after it has been used for that sprite's decision.
- R5: Each sprite evaluated while masked is set (including the one that sets it) subtracts its width (`spr_width`, a count of cells) from the pending-draw count (`pend_cnt`). The count saturates at zero.
- R6: A cycle with `line_start`=1 clears can-mask and masked, loads the overflow flag from `prev_ovf`, and loads `pend_cnt` from `pend_init`.
- R7: Once set, masked stays set until the next `line_start` or reset, whatever positions the later sprites have.
- R8: When `line_start` and `spr_valid` are high in the same cycle, the sprite is dropped: no decision is reported (`dec_valid`=0) and it has no effect on the flags or the count.
- R9: `dec_valid` is 1 exactly one cycle after an accepted sprite strobe. `dec_drawn` is 1 only in a valid cycle for a drawn sprite and is 0 otherwise.
- R10: Synchronous reset clears every flag, the count and both decision outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start-of-scanline pulse |
| prev_ovf | input | 1 | Previous line ran out of pixel capacity |
| pend_init | input | CW | Pending-draw count loaded at line start |
| spr_valid | input | 1 | Sprite strobe |
| spr_xpos | input | XW | Sprite horizontal position |
| spr_width | input | WW | Sprite width in cells |
| dec_valid | output | 1 | Decision valid (one cycle after strobe) |
| dec_drawn | output | 1 | 1 = drawn, 0 = suppressed |
| pend_cnt | output | CW | Pending-draw count |
| can_mask_o | output | 1 | Can-mask flag |
| masked_o | output | 1 | Masked flag |
| dot_ovf_o | output | 1 | Overflow flag |

## Verification
The assertions assume that every input is at a known level on each rising edge. They also assume that a strobe's position and width are meaningful only in the strobe cycle; `pend_init` and `prev_ovf` are likewise meaningful only in a line-start cycle. The stimulus changes every input on the falling edge, so each one is stable around the rising edge. Coincident line-start and strobe cycles are driven on purpose, because the block defines that case as a dropped sprite rather than excluding it. Widths and initial counts are kept small, so saturation at zero is reached often.

// File: rtl/spr_mask_pkg.sv
package spr_mask_pkg;
  // Decision reported for one sprite
  typedef enum logic {
    DEC_SUPPRESS = 1'b0,
    DEC_DRAW     = 1'b1
  } dec_e;

  // Flag state held across one scanline
  typedef struct packed {
    logic can_mask;
    logic masked;
    logic dot_ovf;
  } line_flags_t;
endpackage

// File: rtl/spr_mask_flags.sv
module spr_mask_flags
  import spr_mask_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        line_start,
  input  logic        prev_ovf,
  input  logic        spr_valid,
  input  logic        x_zero,
  output line_flags_t flags,
  output logic        mask_now
);
  line_flags_t st;
  logic        eval;

  assign eval = spr_valid & ~line_start;
  // masked state that applies to the sprite being evaluated now
  assign mask_now = st.masked | (x_zero & (st.can_mask | st.dot_ovf));
  assign flags = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else if (line_start) begin
      st.can_mask <= 1'b0;
      st.masked   <= 1'b0;
      st.dot_ovf  <= prev_ovf;
    end else if (eval) begin
      if (!x_zero) st.can_mask <= 1'b1;
      st.masked  <= mask_now;
      st.dot_ovf <= 1'b0;
    end
  end

  p_canmask_set_r1: assert property (@(posedge clk) disable iff (rst)
    (eval && !x_zero) |=> st.can_mask);
  p_zero_masks_r2: assert property (@(posedge clk) disable iff (rst)
    (eval && x_zero && (st.can_mask || st.dot_ovf)) |=> st.masked);
  p_zero_free_r3: assert property (@(posedge clk) disable iff (rst)
    (eval && x_zero && !st.can_mask && !st.dot_ovf && !st.masked) |=> !st.masked);
  p_ovf_clear_r4: assert property (@(posedge clk) disable iff (rst)
    eval |=> !st.dot_ovf);
  p_line_clear_r6: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (!st.masked && !st.can_mask && st.dot_ovf == $past(prev_ovf)));
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (st.masked && !line_start) |=> st.masked);
endmodule

// File: rtl/spr_mask_counter.sv
module spr_mask_counter #(
  parameter int CW = 8,
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec_en,
  input  logic [WW-1:0] dec_amt,
  output logic [CW-1:0] cnt
);
  localparam int PADW = (CW > WW) ? CW : WW;
  logic [PADW-1:0] amt_ext, cnt_ext;

  assign amt_ext = PADW'(dec_amt);
  assign cnt_ext = PADW'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec_en) begin
      if (cnt_ext > amt_ext) cnt <= CW'(cnt_ext - amt_ext);
      else                   cnt <= '0;
    end
  end

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_en && !load && cnt_ext <= amt_ext) |=> cnt == '0);
  p_monotonic_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_en && !load) |=> cnt <= $past(cnt));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!dec_en && !load) |=> $stable(cnt));
endmodule

// File: rtl/spr_line_mask.sv
module spr_line_mask
  import spr_mask_pkg::*;
#(
  parameter int XW = 9,
  parameter int WW = 3,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          prev_ovf,
  input  logic [CW-1:0] pend_init,
  input  logic          spr_valid,
  input  logic [XW-1:0] spr_xpos,
  input  logic [WW-1:0] spr_width,
  output logic          dec_valid,
  output logic          dec_drawn,
  output logic [CW-1:0] pend_cnt,
  output logic          can_mask_o,
  output logic          masked_o,
  output logic          dot_ovf_o
);
  line_flags_t flags;
  logic        mask_now, x_zero, eval;
  dec_e        dec_q;

  assign x_zero = (spr_xpos == '0);
  assign eval   = spr_valid & ~line_start;

  spr_mask_flags u_flags (
    .clk(clk), .rst(rst), .line_start(line_start), .prev_ovf(prev_ovf),
    .spr_valid(spr_valid), .x_zero(x_zero), .flags(flags), .mask_now(mask_now)
  );

  spr_mask_counter #(.CW(CW), .WW(WW)) u_cnt (
    .clk(clk), .rst(rst), .load(line_start), .load_val(pend_init),
    .dec_en(eval & mask_now), .dec_amt(spr_width), .cnt(pend_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_q     <= DEC_SUPPRESS;
    end else begin
      dec_valid <= eval;
      dec_q     <= (eval && !mask_now) ? DEC_DRAW : DEC_SUPPRESS;
    end
  end

  assign dec_drawn  = (dec_q == DEC_DRAW);
  assign can_mask_o = flags.can_mask;
  assign masked_o   = flags.masked;
  assign dot_ovf_o  = flags.dot_ovf;

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    eval |=> dec_valid);
  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (line_start || !spr_valid) |=> !dec_valid);
  p_drawn_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    dec_drawn |-> dec_valid);
  p_masked_suppress_r2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && masked_o) |-> !dec_drawn);
endmodule

// File: tb/spr_line_mask_test.sv
module spr_line_mask_test;
  localparam int XW = 9, WW = 3, CW = 8;
  logic clk = 0, rst = 1;
  logic line_start = 0, prev_ovf = 0, spr_valid = 0;
  logic [CW-1:0] pend_init = '0;
  logic [XW-1:0] spr_xpos = '0;
  logic [WW-1:0] spr_width = '0;
  logic dec_valid, dec_drawn, can_mask_o, masked_o, dot_ovf_o;
  logic [CW-1:0] pend_cnt;

  int vectors = 0, miscompares = 0, cycles = 0;
  // reference model state
  int m_cm = 0, m_mk = 0, m_ov = 0, m_pc = 0, m_dv = 0, m_dd = 0;

  always #2.5 clk = ~clk;

  spr_line_mask #(.XW(XW), .WW(WW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .line_start(line_start), .prev_ovf(prev_ovf),
    .pend_init(pend_init), .spr_valid(spr_valid), .spr_xpos(spr_xpos),
    .spr_width(spr_width), .dec_valid(dec_valid), .dec_drawn(dec_drawn),
    .pend_cnt(pend_cnt), .can_mask_o(can_mask_o), .masked_o(masked_o),
    .dot_ovf_o(dot_ovf_o)
  );

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cm = 0; m_mk = 0; m_ov = 0; m_pc = 0; m_dv = 0; m_dd = 0;
    end else if (line_start) begin                    // R6, R8
      m_cm = 0; m_mk = 0; m_ov = prev_ovf; m_pc = pend_init; m_dv = 0; m_dd = 0;
    end else if (spr_valid) begin
      if (spr_xpos != 0) m_cm = 1;                    // R1
      else if (m_cm || m_ov) m_mk = 1;                // R2
      m_ov = 0;                                       // R4
      if (m_mk) begin                                 // R5
        m_pc = (m_pc > spr_width) ? m_pc - spr_width : 0;
        m_dd = 0;
      end else m_dd = 1;                              // R3
      m_dv = 1;                                       // R9
    end else begin
      m_dv = 0; m_dd = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare every output on the falling edge
  always @(negedge clk) if (!rst) begin
    chk("R1 can_mask", can_mask_o, m_cm);
    chk("R2/R7 masked", masked_o, m_mk);
    chk("R4 dot_ovf", dot_ovf_o, m_ov);
    chk("R5 pend_cnt", pend_cnt, m_pc);
    chk("R9/R8 dec_valid", dec_valid, m_dv);
    chk("R3/R2 dec_drawn", dec_drawn, m_dd);
  end

  task automatic idle();
    @(negedge clk); line_start = 0; spr_valid = 0;
  endtask
  task automatic newline(int ovf, int init);
    @(negedge clk); line_start = 1; spr_valid = 0; prev_ovf = ovf[0]; pend_init = CW'(init);
  endtask
  task automatic sprite(int x, int w);
    @(negedge clk); line_start = 0; spr_valid = 1; spr_xpos = XW'(x); spr_width = WW'(w);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 reset dec_valid", dec_valid, 0);
    chk("R10 reset pend_cnt", pend_cnt, 0);
    chk("R10 reset masked", masked_o, 0);
    rst = 0;
    // R3: zero-x first with no overflow -> drawn; R1 then R2 masks
    newline(0, 10);
    sprite(0, 2); sprite(5, 3); sprite(0, 4); sprite(40, 3); sprite(7, 2);
    idle(); idle();
    // R4/R2: overflow from previous line masks first zero sprite
    newline(1, 3);
    sprite(0, 2); sprite(9, 4); idle();
    // R4: overflow cleared by nonzero sprite; R7 sticky after mask
    newline(1, 20);
    sprite(3, 1); sprite(0, 1); sprite(0, 1); sprite(12, 7); idle();
    // R8: coincident line start and strobe drops the sprite
    newline(0, 5);
    @(negedge clk); line_start = 1; spr_valid = 1; spr_xpos = 0; spr_width = 3;
    pend_init = 5; prev_ovf = 0;
    sprite(0, 3); idle();
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      line_start = ($urandom_range(0, 19) == 0);
      prev_ovf   = $urandom_range(0, 1);
      pend_init  = CW'($urandom_range(0, 16));
      spr_valid  = ($urandom_range(0, 9) < 6);
      spr_xpos   = ($urandom_range(0, 9) < 3) ? '0 : XW'($urandom_range(1, 511));
      spr_width  = WW'($urandom_range(0, 7));
    end
    idle(); idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule